// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block sits at the command edge of a DDR3 memory device model or a protocol monitor. On every rising clock edge it samples the active-low command strobes, the clock enable, the bank-address bits and the address bus. It turns that sample into a registered command code and the qualifiers that go with that command. Address pins whose meaning depends on the command are split out into separate flags. The auto-precharge and precharge-all requests both come from address bit 10. The burst-chop request comes from address bit 12. The mode-register index comes from the bank bits.

All decoded outputs appear one cycle after the pins are sampled. Any qualifier that does not belong to the current command is held at zero, so downstream logic can use the qualifiers without decoding the command again.

The block also keeps a shadow of two settings from mode register 1. One is the termination-strobe enable. The other is whether on-die termination is enabled at all. Both are updated only by a live mode-register write that targets register 1, and each update appears in the same cycle as the decoded mode-register command.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cmd_valid is 0, cmd is NOP (code 0), and every other output is 0.
- R2: With cke=1 and cs_n=0, the pins {ras_n,cas_n,we_n} decode one cycle later with cmd_valid=1. The mapping is: 111 gives NOP (0), 011 gives ACT (1), 101 gives RD (2), 100 gives WR (3), 010 gives PRE (4), 001 gives REF (5), 000 gives MRS (6) and 110 gives ZQC (7). cmd is NOP whenever cmd_valid is 0.
- R3: A sample with cs_n=1 gives cmd_valid=0, cmd=NOP and all qualifiers 0 on the next cycle.
- R4: A sample with cke=0 gives cmd_valid=0, cmd=NOP and all qualifiers 0 on the next cycle, whatever the other pins are.
- R5: For ACT, bank equals ba and addr_out equals the full 14-bit address.
- R6: For RD and WR, bank equals ba and addr_out holds address bits 9..0, zero-extended. For REF, ZQC and NOP, bank and addr_out are 0.
- R7: auto_pre equals address bit 10 for RD and WR, and is 0 for every other command.
- R8: burst_chop is the inverse of address bit 12 for RD and WR (bit 12 low means chop to 4), and is 0 for every other command.
- R9: For PRE, pre_all equals address bit 10. When pre_all is 1, bank is 0. Otherwise bank equals ba. pre_all is 0 for every other command.
- R10: For MRS, mr_sel equals ba and mr_op equals the address bus. For every other command, both are 0.
- R11: A live MRS with ba=1 sets tdqs_en to address bit 11 and odt_en to the OR of address bits 2, 6 and 9, visible in the same cycle as the decoded MRS. An MRS to any other register, or an MRS masked by cs_n or cke, leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses decoding |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / mode-register index |
| addr | input | 14 | Address bus / mode-register opcode |
| cmd_valid | output | 1 | A command was decoded |
| cmd | output | 3 | Command code (see R2) |
| bank | output | 3 | Target bank |
| addr_out | output | 14 | Row or column address |
| auto_pre | output | 1 | Auto-precharge requested |
| pre_all | output | 1 | Precharge targets all banks |
| burst_chop | output | 1 | Burst chopped to 4 |
| mr_sel | output | 3 | Mode register being written |
| mr_op | output | 14 | Mode-register opcode |
| tdqs_en | output | 1 | Shadowed termination-strobe enable |
| odt_en | output | 1 | Shadowed termination enable |

## Verification
The hardest case to reach from the ports is a masked mode-register write to register 1. The shadow must keep its old values even though the address bus carries a clearing opcode. The stimulus first sets both shadow bits with a live write to register 1. It then sends clearing opcodes to register 1 under cs_n high and under cke low, and next to register 3 while live. It checks after each step that tdqs_en and odt_en are still 1, and only then clears them with a live write to register 1.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_ZQC = 3'd7
    } cmd_e;

endpackage

// File: rtl/ddr3_cmd_classify.sv
module ddr3_cmd_classify
    import ddr3_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic selected,
    output cmd_e kind
);
    always_comb begin
        selected = !cs_n;
        unique case ({ras_n, cas_n, we_n})
            3'b011:  kind = CMD_ACT;
            3'b101:  kind = CMD_RD;
            3'b100:  kind = CMD_WR;
            3'b010:  kind = CMD_PRE;
            3'b001:  kind = CMD_REF;
            3'b000:  kind = CMD_MRS;
            3'b110:  kind = CMD_ZQC;
            default: kind = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/ddr3_mr1_shadow.sv
module ddr3_mr1_shadow #(
    parameter int ADDR_W   = 14,
    parameter int TDQS_BIT = 11,
    parameter int RTT_B0   = 2,
    parameter int RTT_B1   = 6,
    parameter int RTT_B2   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] op,
    output logic              tdqs_en,
    output logic              odt_en
);
    typedef struct packed {
        logic tdqs;
        logic odt;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            sh_d.tdqs = op[TDQS_BIT];
            sh_d.odt  = op[RTT_B0] | op[RTT_B1] | op[RTT_B2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tdqs_en = sh_q.tdqs;
    assign odt_en  = sh_q.odt;
endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
    import ddr3_cmd_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int ADDR_W  = 14,
    parameter int COL_W   = 10,
    parameter int AP_BIT  = 10,
    parameter int BC_BIT  = 12,
    parameter int MR_SHAD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr_out,
    output logic              auto_pre,
    output logic              pre_all,
    output logic              burst_chop,
    output logic [BANK_W-1:0] mr_sel,
    output logic [ADDR_W-1:0] mr_op,
    output logic              tdqs_en,
    output logic              odt_en
);
    localparam int PAD_W = ADDR_W - COL_W;

    typedef struct packed {
        logic              valid;
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic              ap;
        logic              all;
        logic              chop;
        logic [BANK_W-1:0] mr_sel;
        logic [ADDR_W-1:0] mr_op;
    } dec_t;

    dec_t dec_d, dec_q;
    logic selected;
    cmd_e kind;
    logic live;
    logic shadow_wr;

    ddr3_cmd_classify classify_i (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .selected (selected),
        .kind     (kind)
    );

    always_comb begin
        live      = cke && selected;
        shadow_wr = live && (kind == CMD_MRS) && (ba == BANK_W'(MR_SHAD));
        dec_d     = '0;
        dec_d.cmd = CMD_NOP;
        if (live) begin
            dec_d.valid = 1'b1;
            dec_d.cmd   = kind;
            unique case (kind)
                CMD_ACT: begin
                    dec_d.bank = ba;
                    dec_d.addr = addr;
                end
                CMD_RD, CMD_WR: begin
                    dec_d.bank = ba;
                    dec_d.addr = {{PAD_W{1'b0}}, addr[COL_W-1:0]};
                    dec_d.ap   = addr[AP_BIT];
                    dec_d.chop = !addr[BC_BIT];
                end
                CMD_PRE: begin
                    dec_d.all  = addr[AP_BIT];
                    dec_d.bank = addr[AP_BIT] ? '0 : ba;
                end
                CMD_MRS: begin
                    dec_d.mr_sel = ba;
                    dec_d.mr_op  = addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    ddr3_mr1_shadow #(.ADDR_W(ADDR_W)) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (shadow_wr),
        .op      (addr),
        .tdqs_en (tdqs_en),
        .odt_en  (odt_en)
    );

    assign cmd_valid  = dec_q.valid;
    assign cmd        = dec_q.cmd;
    assign bank       = dec_q.bank;
    assign addr_out   = dec_q.addr;
    assign auto_pre   = dec_q.ap;
    assign pre_all    = dec_q.all;
    assign burst_chop = dec_q.chop;
    assign mr_sel     = dec_q.mr_sel;
    assign mr_op      = dec_q.mr_op;
endmodule

// File: rtl/ddr3_cmd_decoder_chk.sv
module ddr3_cmd_decoder_chk
    import ddr3_cmd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic              auto_pre,
    input logic              pre_all,
    input logic              burst_chop,
    input logic [BANK_W-1:0] mr_sel,
    input logic [ADDR_W-1:0] mr_op,
    input logic              tdqs_en,
    input logic              odt_en
);
    // R3
    cs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !cmd_valid);

    // R4
    cke_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> !cmd_valid);

    // R2
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd == 3'(CMD_NOP)));

    // R7
    ap_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd == 3'(CMD_RD) || cmd == 3'(CMD_WR)));

    // R8
    chop_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_chop |-> (cmd == 3'(CMD_RD) || cmd == 3'(CMD_WR)));

    // R9
    pre_all_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> (cmd == 3'(CMD_PRE) && bank == '0));

    // R10
    mr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 3'(CMD_MRS)) |-> (mr_sel == '0 && mr_op == '0));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd == 3'(CMD_MRS) && mr_sel == BANK_W'(1))
            |-> ($stable(tdqs_en) && $stable(odt_en)));
endmodule

bind ddr3_cmd_decoder ddr3_cmd_decoder_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .bank       (bank),
    .auto_pre   (auto_pre),
    .pre_all    (pre_all),
    .burst_chop (burst_chop),
    .mr_sel     (mr_sel),
    .mr_op      (mr_op),
    .tdqs_en    (tdqs_en),
    .odt_en     (odt_en)
);

// File: tb/ddr3_cmd_decoder_tb.sv
module ddr3_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic        cmd_valid, auto_pre, pre_all, burst_chop, tdqs_en, odt_en;
    logic [2:0]  cmd, bank, mr_sel;
    logic [13:0] addr_out, mr_op;

    int tests = 0;
    int fails = 0;
    logic tdqs_m = 1'b0, odt_m = 1'b0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic        valid;
        logic [2:0]  cmd;
        logic [2:0]  bank;
        logic [13:0] addr;
        logic        ap, all, chop;
        logic [2:0]  mr_sel;
        logic [13:0] mr_op;
        logic        tdqs, odt;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    ddr3_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_valid(cmd_valid), .cmd(cmd), .bank(bank), .addr_out(addr_out),
        .auto_pre(auto_pre), .pre_all(pre_all), .burst_chop(burst_chop),
        .mr_sel(mr_sel), .mr_op(mr_op), .tdqs_en(tdqs_en), .odt_en(odt_en)
    );

    function automatic string show(input logic v, input logic [2:0] c, input logic [2:0] b,
                                   input logic [13:0] a, input logic p, input logic l,
                                   input logic h, input logic [2:0] s, input logic [13:0] o,
                                   input logic t, input logic d);
        return $sformatf("v=%0b cmd=%0d bank=%0d addr=%h ap=%0b all=%0b chop=%0b sel=%0d op=%h tdqs=%0b odt=%0b",
                         v, c, b, a, p, l, h, s, o, t, d);
    endfunction

    task automatic compare(input exp_t e);
        string act, ex;
        tests++;
        act = show(cmd_valid, cmd, bank, addr_out, auto_pre, pre_all, burst_chop, mr_sel, mr_op, tdqs_en, odt_en);
        ex  = show(e.valid, e.cmd, e.bank, e.addr, e.ap, e.all, e.chop, e.mr_sel, e.mr_op, e.tdqs, e.odt);
        if (act !== ex) begin
            fails++;
            $display("FAIL %s: actual {%s} expected {%s}", e.tag, act, ex);
        end
    endtask

    // Expected values follow the requirement text; command code from {ras,cas,we}
    task automatic drive(input string tag, input logic k, input logic c, input logic [2:0] rcw,
                         input logic [2:0] b, input logic [13:0] a);
        exp_t e;
        logic [2:0] code;
        e = '{tag: tag, valid: 0, cmd: 0, bank: 0, addr: 0, ap: 0, all: 0, chop: 0,
              mr_sel: 0, mr_op: 0, tdqs: 0, odt: 0};
        case (rcw)
            3'b011: code = 3'd1; 3'b101: code = 3'd2; 3'b100: code = 3'd3;
            3'b010: code = 3'd4; 3'b001: code = 3'd5; 3'b000: code = 3'd6;
            3'b110: code = 3'd7; default: code = 3'd0;
        endcase
        if (k && !c) begin
            e.valid = 1'b1;
            e.cmd   = code;
            if (code == 3'd1) begin e.bank = b; e.addr = a; end
            if (code == 3'd2 || code == 3'd3) begin
                e.bank = b; e.addr = {4'b0, a[9:0]}; e.ap = a[10]; e.chop = !a[12];
            end
            if (code == 3'd4) begin e.all = a[10]; e.bank = a[10] ? 3'd0 : b; end
            if (code == 3'd6) begin
                e.mr_sel = b; e.mr_op = a;
                if (b == 3'd1) begin tdqs_m = a[11]; odt_m = a[2] | a[6] | a[9]; end
            end
        end
        e.tdqs = tdqs_m;
        e.odt  = odt_m;
        @(negedge clk);
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(posedge clk);
        #1 sb.push_back(e);
    endtask

    // Monitor: compares one result per cycle, half a period after it is registered
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z = '{tag: "R1 reset", valid: 0, cmd: 0, bank: 0, addr: 0, ap: 0, all: 0, chop: 0,
              mr_sel: 0, mr_op: 0, tdqs: 0, odt: 0};
        repeat (3) @(negedge clk);
        compare(z);                                  // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        z.tag = "R1 after reset";
        compare(z);                                  // R1

        drive("R2 nop",        1, 0, 3'b111, 3'd4, 14'h3FFF);
        drive("R5 act",        1, 0, 3'b011, 3'd5, 14'h2ABC);
        drive("R6 R7 R8 rd",   1, 0, 3'b101, 3'd3, 14'h17FF);
        drive("R6 R7 R8 wr",   1, 0, 3'b100, 3'd7, 14'h0123);
        drive("R9 pre one",    1, 0, 3'b010, 3'd6, 14'h3BFF);
        drive("R9 pre all",    1, 0, 3'b010, 3'd6, 14'h0400);
        drive("R2 R6 ref",     1, 0, 3'b001, 3'd2, 14'h1555);
        drive("R2 R6 zqc",     1, 0, 3'b110, 3'd1, 14'h0400);
        drive("R10 mrs mr2",   1, 0, 3'b000, 3'd2, 14'h0A5A);
        drive("R11 mr1 set",   1, 0, 3'b000, 3'd1, 14'h0840);
        drive("R3 cs masked rd", 1, 1, 3'b101, 3'd3, 14'h1400);
        drive("R4 cke low act",  0, 0, 3'b011, 3'd5, 14'h2ABC);
        drive("R11 R3 masked mr1", 1, 1, 3'b000, 3'd1, 14'h0000);
        drive("R11 R4 cke mr1",    0, 0, 3'b000, 3'd1, 14'h0000);
        drive("R11 mr3 keeps",     1, 0, 3'b000, 3'd3, 14'h0000);
        drive("R11 mr1 odt only",  1, 0, 3'b000, 3'd1, 14'h0004);
        drive("R11 mr1 clear",     1, 0, 3'b000, 3'd1, 14'h0000);
        drive("R7 R8 rd no ap chop", 1, 0, 3'b101, 3'd0, 14'h0000);
        drive("R2 nop tail",       1, 0, 3'b111, 3'd0, 14'h0000);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule